// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps a circular record of every instruction the issue logic admits, in program order, and holds each result between the moment a functional unit produces it and the moment the instruction retires. Each admitted instruction receives an entry number. That number goes back to the issuer and later tags the instruction's result when it appears on the result broadcast bus. While an entry waits to retire, the issuer can read its ready flag and value through a lookup port. This lets it take an operand that is complete but not yet committed.

Only the oldest entry may retire, and only once its result has arrived. A register-writing instruction updates the register file at that point and a store is released to memory. A branch whose prediction held simply leaves the buffer. A branch that was mispredicted, or any entry that carries an exception, empties the whole buffer when it reaches the oldest position. A mispredicted branch also raises a redirect carrying the branch's result value as the target. Nothing architectural is written before retirement.

Top module: `rob_core`

## Requirements
- R1: A synchronous active-high reset leaves the buffer empty, with `alloc_tag` at 0, all retirement strobes (`rf_we`, `mem_we`, `redirect`, `except_o`) low, and `lookup_ready`/`lookup_value` at 0.
- R2: `alloc_grant` is combinationally high exactly when `alloc_req` and `rs_free` are high, fewer than 8 entries are occupied, and no flush happens in the same cycle. A granted request takes an entry at the next clock edge, and no more than one entry is taken per cycle.
- R3: `alloc_tag` shows the entry number the next granted instruction receives. Numbers are handed out 0,1,...,7,0,... in order, starting from 0 after reset or a flush.
- R4: A broadcast (`bcast_valid` high) writes `bcast_value`, the misprediction flag and the exception flag into entry `bcast_tag`, and marks that entry ready at the next edge.
- R5: At most one entry retires per clock edge. It is always the oldest occupied entry, and it retires only once it is ready, so retirement follows program order even when results arrive out of order.
- R6: The kind encoding is 2'b00 for a register write, 2'b01 for a store and 2'b10 for a branch. When a ready register entry without an exception retires, `rf_we` pulses for one cycle after that edge with `rf_addr` equal to the low 5 bits of its destination and `rf_data` equal to its value. A store in the same position pulses `mem_we` with `mem_addr` equal to its full destination and `mem_data` equal to its value.
- R7: A branch that retires with a clear misprediction flag raises no strobe. With the flag set, `redirect` pulses for one cycle with `redirect_target` equal to its value, and the buffer is flushed.
- R8: An entry whose exception flag is set raises nothing until it becomes the oldest. Then `except_o` pulses for one cycle, no register or memory write occurs, and the buffer is flushed. An exception takes precedence over a branch misprediction.
- R9: `lookup_ready` and `lookup_value` give, one cycle later, the ready flag and stored value of entry `lookup_tag` as they stood just before the clock edge.
- R10: A flush empties the buffer, returns both pointers to entry 0 and clears every ready flag. A request made in the flush cycle is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Issuer wants an entry this cycle |
| rs_free | input | 1 | A reservation station is available |
| alloc_kind | input | 2 | Kind of the instruction being admitted |
| alloc_dest | input | DEST_W | Register number or memory address |
| alloc_grant | output | 1 | Admission accepted this cycle |
| alloc_tag | output | TAG_W | Entry number the next admission receives |
| bcast_valid | input | 1 | Result broadcast present |
| bcast_tag | input | TAG_W | Entry the broadcast belongs to |
| bcast_value | input | DATA_W | Result value or branch target |
| bcast_mispredict | input | 1 | Branch outcome differed from prediction |
| bcast_except | input | 1 | Instruction raised an exception |
| lookup_tag | input | TAG_W | Entry to read for operand bypass |
| lookup_ready | output | 1 | Ready flag of the looked-up entry |
| lookup_value | output | DATA_W | Stored value of the looked-up entry |
| rf_we | output | 1 | Register file write strobe |
| rf_addr | output | REG_W | Register number written |
| rf_data | output | DATA_W | Register data written |
| mem_we | output | 1 | Memory store strobe |
| mem_addr | output | DEST_W | Store address |
| mem_data | output | DATA_W | Store data |
| redirect | output | 1 | Mispredicted branch retired |
| redirect_target | output | DATA_W | Value carried by the mispredicted branch |
| except_o | output | 1 | Exception taken at retirement |

## Verification
`alloc_grant` is combinational, so it is compared a short delay after each input change, in the same cycle. A broadcast updates an entry at the edge on which it is sampled. That entry can retire at the following edge, and the matching strobe is visible for the cycle after that edge, so retirement results lag the broadcast by two edges. `alloc_tag` and the lookup outputs change one edge after their cause. The reference model advances at every rising edge using the inputs held since the previous falling edge. It predicts the registered outputs for the coming cycle, and all comparisons happen at the falling edge, halfway between two active edges.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_fire,
  input  logic             commit_fire,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire)  tail <= step(tail);
      if (commit_fire) head <= step(head);
      count <= count + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    !(alloc_fire && full));
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    !(commit_fire && empty));
  p_tail_step_r3: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && !flush) |=> (tail == step($past(tail))));
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && head == '0 && tail == '0));

endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = $clog2(DEPTH),
  parameter int DATA_W = 32,
  parameter int DEST_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc_fire,
  input  logic [TAG_W-1:0]  tail,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              bcast_valid,
  input  logic [TAG_W-1:0]  bcast_tag,
  input  logic [DATA_W-1:0] bcast_value,
  input  logic              bcast_mispredict,
  input  logic              bcast_except,
  input  logic              commit_fire,
  input  logic [TAG_W-1:0]  head,
  output logic [1:0]        head_kind,
  output logic [DEST_W-1:0] head_dest,
  output logic [DATA_W-1:0] head_value,
  output logic              head_ready,
  output logic              head_mis,
  output logic              head_exc,
  input  logic [TAG_W-1:0]  lookup_tag,
  output logic              lookup_ready,
  output logic [DATA_W-1:0] lookup_value
);

  logic [1:0]        kind_mem [DEPTH];
  logic [DEST_W-1:0] dest_mem [DEPTH];
  logic [DATA_W-1:0] val_mem  [DEPTH];
  logic              mis_mem  [DEPTH];
  logic              exc_mem  [DEPTH];
  logic [DEPTH-1:0]  ready_q;

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      kind_mem[tail] <= alloc_kind;
      dest_mem[tail] <= alloc_dest;
    end
  end

  always_ff @(posedge clk) begin
    if (bcast_valid) begin
      val_mem[bcast_tag] <= bcast_value;
      mis_mem[bcast_tag] <= bcast_mispredict;
      exc_mem[bcast_tag] <= bcast_except;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ready
    always_ff @(posedge clk) begin
      if (rst || flush)
        ready_q[i] <= 1'b0;
      else if (alloc_fire && tail == TAG_W'(i))
        ready_q[i] <= 1'b0;
      else if (bcast_valid && bcast_tag == TAG_W'(i))
        ready_q[i] <= 1'b1;
      else if (commit_fire && head == TAG_W'(i))
        ready_q[i] <= 1'b0;
    end
  end

  assign head_kind  = kind_mem[head];
  assign head_dest  = dest_mem[head];
  assign head_value = val_mem[head];
  assign head_mis   = mis_mem[head];
  assign head_exc   = exc_mem[head];
  assign head_ready = ready_q[head];

  always_ff @(posedge clk) begin
    if (rst) begin
      lookup_ready <= 1'b0;
      lookup_value <= '0;
    end else begin
      lookup_ready <= ready_q[lookup_tag];
      lookup_value <= val_mem[lookup_tag];
    end
  end

  p_bcast_sets_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (bcast_valid && !flush && !(alloc_fire && tail == bcast_tag))
      |=> ready_q[$past(bcast_tag)]);

endmodule

// File: rtl/rob_commit.sv
module rob_commit
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              empty,
  input  logic              head_ready,
  input  logic [1:0]        head_kind,
  input  logic [DEST_W-1:0] head_dest,
  input  logic [DATA_W-1:0] head_value,
  input  logic              head_mis,
  input  logic              head_exc,
  output logic              commit_fire,
  output logic              flush,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              mem_we,
  output logic [DEST_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              redirect,
  output logic [DATA_W-1:0] redirect_target,
  output logic              except_o
);

  rob_kind_e kind;
  logic      exc_take, mis_take, reg_take, st_take;

  assign kind        = rob_kind_e'(head_kind);
  assign commit_fire = !empty && head_ready;
  assign exc_take    = commit_fire && head_exc;
  assign mis_take    = commit_fire && !head_exc && kind == KIND_BRANCH && head_mis;
  assign reg_take    = commit_fire && !head_exc && kind == KIND_REG;
  assign st_take     = commit_fire && !head_exc && kind == KIND_STORE;
  assign flush       = exc_take || mis_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we           <= 1'b0;
      rf_addr         <= '0;
      rf_data         <= '0;
      mem_we          <= 1'b0;
      mem_addr        <= '0;
      mem_data        <= '0;
      redirect        <= 1'b0;
      redirect_target <= '0;
      except_o        <= 1'b0;
    end else begin
      rf_we           <= reg_take;
      rf_addr         <= head_dest[REG_W-1:0];
      rf_data         <= head_value;
      mem_we          <= st_take;
      mem_addr        <= head_dest;
      mem_data        <= head_value;
      redirect        <= mis_take;
      redirect_target <= head_value;
      except_o        <= exc_take;
    end
  end

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, mem_we, redirect, except_o}));
  p_exc_flushed_r8: assert property (@(posedge clk) disable iff (rst)
    except_o |-> $past(flush));

endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  parameter int REG_W  = 5,
  parameter int TAG_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic              rs_free,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  output logic              alloc_grant,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              bcast_valid,
  input  logic [TAG_W-1:0]  bcast_tag,
  input  logic [DATA_W-1:0] bcast_value,
  input  logic              bcast_mispredict,
  input  logic              bcast_except,
  input  logic [TAG_W-1:0]  lookup_tag,
  output logic              lookup_ready,
  output logic [DATA_W-1:0] lookup_value,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              mem_we,
  output logic [DEST_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              redirect,
  output logic [DATA_W-1:0] redirect_target,
  output logic              except_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              full, empty, commit_fire, flush;
  logic [1:0]        head_kind;
  logic [DEST_W-1:0] head_dest;
  logic [DATA_W-1:0] head_value;
  logic              head_ready, head_mis, head_exc;

  assign alloc_grant = alloc_req && rs_free && !full && !flush;
  assign alloc_tag   = tail;

  rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) ptrs_i (
    .clk(clk), .rst(rst), .alloc_fire(alloc_grant), .commit_fire(commit_fire),
    .flush(flush), .head(head), .tail(tail), .count(count), .full(full),
    .empty(empty)
  );

  rob_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .DEST_W(DEST_W)) store_i (
    .clk(clk), .rst(rst), .flush(flush), .alloc_fire(alloc_grant), .tail(tail),
    .alloc_kind(alloc_kind), .alloc_dest(alloc_dest), .bcast_valid(bcast_valid),
    .bcast_tag(bcast_tag), .bcast_value(bcast_value),
    .bcast_mispredict(bcast_mispredict), .bcast_except(bcast_except),
    .commit_fire(commit_fire), .head(head), .head_kind(head_kind),
    .head_dest(head_dest), .head_value(head_value), .head_ready(head_ready),
    .head_mis(head_mis), .head_exc(head_exc), .lookup_tag(lookup_tag),
    .lookup_ready(lookup_ready), .lookup_value(lookup_value)
  );

  rob_commit #(.DATA_W(DATA_W), .DEST_W(DEST_W), .REG_W(REG_W)) commit_i (
    .clk(clk), .rst(rst), .empty(empty), .head_ready(head_ready),
    .head_kind(head_kind), .head_dest(head_dest), .head_value(head_value),
    .head_mis(head_mis), .head_exc(head_exc), .commit_fire(commit_fire),
    .flush(flush), .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .redirect(redirect), .redirect_target(redirect_target), .except_o(except_o)
  );

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

endmodule

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alloc_req = 0, rs_free = 0;
  logic [1:0]  alloc_kind = 0;
  logic [31:0] alloc_dest = 0;
  logic        alloc_grant;
  logic [2:0]  alloc_tag;
  logic        bcast_valid = 0;
  logic [2:0]  bcast_tag = 0;
  logic [31:0] bcast_value = 0;
  logic        bcast_mispredict = 0, bcast_except = 0;
  logic [2:0]  lookup_tag = 0;
  logic        lookup_ready;
  logic [31:0] lookup_value;
  logic        rf_we, mem_we, redirect, except_o;
  logic [4:0]  rf_addr;
  logic [31:0] rf_data, mem_addr, mem_data, redirect_target;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rob_core dut_i (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .rs_free(rs_free),
    .alloc_kind(alloc_kind), .alloc_dest(alloc_dest), .alloc_grant(alloc_grant),
    .alloc_tag(alloc_tag), .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
    .bcast_value(bcast_value), .bcast_mispredict(bcast_mispredict),
    .bcast_except(bcast_except), .lookup_tag(lookup_tag),
    .lookup_ready(lookup_ready), .lookup_value(lookup_value), .rf_we(rf_we),
    .rf_addr(rf_addr), .rf_data(rf_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .redirect(redirect), .redirect_target(redirect_target),
    .except_o(except_o)
  );

  // reference model state
  int          m_q[$];
  logic [1:0]  m_kind [8];
  logic [31:0] m_dest [8];
  logic [31:0] m_val  [8];
  bit          m_rdy  [8];
  bit          m_mis  [8];
  bit          m_exc  [8];
  int          m_tail;
  bit          e_rf_we, e_mem_we, e_redir, e_exc, e_lk_rdy;
  logic [4:0]  e_rf_addr;
  logic [31:0] e_rf_data, e_mem_addr, e_mem_data, e_target, e_lk_val;
  int          h;
  bit          hc, fl, g;

  function automatic bit head_commits();
    return m_q.size() > 0 && m_rdy[m_q[0]];
  endfunction

  function automatic bit head_flushes();
    int hh;
    if (!head_commits()) return 0;
    hh = m_q[0];
    return m_exc[hh] || (m_kind[hh] == 2'b10 && m_mis[hh]);
  endfunction

  function automatic bit model_grant();
    return alloc_req && rs_free && m_q.size() < 8 && !head_flushes();
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete();
      m_tail = 0;
      for (int i = 0; i < 8; i++) m_rdy[i] = 0;
      e_rf_we = 0; e_mem_we = 0; e_redir = 0; e_exc = 0;
      e_lk_rdy = 0; e_lk_val = 0;
    end else begin
      hc = head_commits();
      fl = head_flushes();
      g  = model_grant();
      h  = hc ? m_q[0] : 0;
      e_lk_rdy   = m_rdy[lookup_tag];
      e_lk_val   = m_val[lookup_tag];
      e_rf_we    = hc && !m_exc[h] && m_kind[h] == 2'b00;
      e_rf_addr  = m_dest[h][4:0];
      e_rf_data  = m_val[h];
      e_mem_we   = hc && !m_exc[h] && m_kind[h] == 2'b01;
      e_mem_addr = m_dest[h];
      e_mem_data = m_val[h];
      e_redir    = hc && !m_exc[h] && m_kind[h] == 2'b10 && m_mis[h];
      e_target   = m_val[h];
      e_exc      = hc && m_exc[h];
      if (hc) begin
        m_rdy[h] = 0;
        void'(m_q.pop_front());
      end
      if (bcast_valid) begin
        m_val[bcast_tag] = bcast_value;
        m_mis[bcast_tag] = bcast_mispredict;
        m_exc[bcast_tag] = bcast_except;
        m_rdy[bcast_tag] = 1;
      end
      if (g) begin
        m_kind[m_tail] = alloc_kind;
        m_dest[m_tail] = alloc_dest;
        m_rdy[m_tail]  = 0;
        m_q.push_back(m_tail);
        m_tail = (m_tail + 1) % 8;
      end
      if (fl) begin
        m_q.delete();
        m_tail = 0;
        for (int i = 0; i < 8; i++) m_rdy[i] = 0;
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic check_regs();
    check(alloc_tag == 3'(m_tail), "R3 alloc_tag", 32'(alloc_tag), 32'(m_tail));
    check(lookup_ready == e_lk_rdy, "R4 R9 lookup_ready", 32'(lookup_ready), 32'(e_lk_rdy));
    if (e_lk_rdy)
      check(lookup_value == e_lk_val, "R4 R9 lookup_value", lookup_value, e_lk_val);
    check(rf_we == e_rf_we, "R5 R6 rf_we", 32'(rf_we), 32'(e_rf_we));
    if (e_rf_we) begin
      check(rf_addr == e_rf_addr, "R6 rf_addr", 32'(rf_addr), 32'(e_rf_addr));
      check(rf_data == e_rf_data, "R6 rf_data", rf_data, e_rf_data);
    end
    check(mem_we == e_mem_we, "R5 R6 mem_we", 32'(mem_we), 32'(e_mem_we));
    if (e_mem_we) begin
      check(mem_addr == e_mem_addr, "R6 mem_addr", mem_addr, e_mem_addr);
      check(mem_data == e_mem_data, "R6 mem_data", mem_data, e_mem_data);
    end
    check(redirect == e_redir, "R7 redirect", 32'(redirect), 32'(e_redir));
    if (e_redir)
      check(redirect_target == e_target, "R7 redirect_target", redirect_target, e_target);
    check(except_o == e_exc, "R8 R10 except_o", 32'(except_o), 32'(e_exc));
  endtask

  // one cycle: check registered outputs, drive, check grant
  task automatic cycle(input int p_req, input int p_bc, input int p_mis, input int p_exc);
    int pend[$];
    @(negedge clk);
    check_regs();
    alloc_req  = ($urandom_range(99) < p_req);
    rs_free    = ($urandom_range(99) < 90);
    alloc_kind = 2'($urandom_range(2));
    alloc_dest = $urandom;
    lookup_tag = 3'($urandom_range(7));
    pend.delete();
    foreach (m_q[i]) if (!m_rdy[m_q[i]]) pend.push_back(m_q[i]);
    bcast_valid = (pend.size() > 0) && ($urandom_range(99) < p_bc);
    if (bcast_valid) bcast_tag = 3'(pend[$urandom_range(pend.size() - 1)]);
    bcast_value      = $urandom;
    bcast_mispredict = ($urandom_range(99) < p_mis);
    bcast_except     = ($urandom_range(99) < p_exc);
    #1;
    check(alloc_grant == model_grant(), "R2 R10 alloc_grant",
          32'(alloc_grant), 32'(model_grant()));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(alloc_tag == 0, "R1 alloc_tag", 32'(alloc_tag), 0);
    check(!rf_we && !mem_we && !redirect && !except_o, "R1 strobes",
          {28'd0, rf_we, mem_we, redirect, except_o}, 0);
    check(lookup_ready == 0 && lookup_value == 0, "R1 lookup", lookup_value, 0);
    // fill to capacity with no results: grant must drop at 8 entries (R2)
    for (int i = 0; i < 14; i++) cycle(100, 0, 0, 0);
    // results out of order, no faults: in-order retirement (R5)
    for (int i = 0; i < 40; i++) cycle(0, 40, 0, 0);
    // steady traffic, no faults
    for (int i = 0; i < 1500; i++) cycle(70, 50, 0, 0);
    // mispredictions and exceptions mixed in (R7 R8 R10)
    for (int i = 0; i < 2500; i++) cycle(80, 60, 15, 5);
    // heavy issue, sparse results
    for (int i = 0; i < 1000; i++) cycle(95, 20, 10, 3);
    // drain
    for (int i = 0; i < 60; i++) cycle(0, 80, 0, 0);
    @(negedge clk);
    check_regs();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule